// File: doc/BRIEF.md
# Truth-Table Fitness Evaluator

This block scores one candidate configuration of a layered gate array that drives a six-switch commutation bridge from three rotor position bits. On a start pulse it first checks the configuration's connection matrices against the structural rules of the array. A configuration that breaks any rule gets a score of zero at once, and the array is never exercised. A configuration that passes the rules is exercised with the six legal position codes in turn. For each code the block compares all six array outputs with an expected table and adds one point for every bit that matches. The best possible score is 36.

The array is outside this block. The evaluator drives the array's position input and reads its six outputs back. The connection matrices and the expected table are presented as flat vectors and must stay stable from start until done. Function selection bits for the cells do not affect any rule, so the evaluator does not see them.

Top module: `fte_eval`

## Requirements
- R1: After reset, `done` is 0, `score` is 0 and `arr_in` is 000.
- R2: If any primary input has no 1 anywhere in the first connection matrix, the configuration is invalid. Bit `cfg_in_conn[j*3+i]` connects input i to cell j of the first evolvable column.
- R3: The configuration is invalid if any evolvable cell has fewer than two 1s among its connections from the column to its left. For first-column cell j these are bits `[j*3 +: 3]`. For stage s cell j these are `cfg_mid_conn[(s*8+j)*8 +: 8]`.
- R4: The configuration is invalid unless every output selection field `cfg_out_sel[o*8 +: 8]` has exactly one 1.
- R5: An invalid configuration produces a `done` pulse 2 clock edges after the edge that samples `start`, with `score` 0. `arr_in` leaves 000 at no point during it.
- R6: A valid configuration is swept over the codes 001 to 110 in ascending order. Each code is held for two cycles, and `arr_in` is 000 whenever the block is not sweeping.
- R7: The score is the number of positions where `arr_out[o]` equals `exp_table[k*6+o]` while code k+1 is applied. The score ranges from 0 to 36.
- R8: For a valid configuration, `done` is a single-cycle pulse 14 edges after the start edge. `score` then holds its value until the next accepted start.
- R9: A `start` raised while an evaluation is in progress has no effect.
- R10: The outputs are sampled one full cycle after each code is applied, so an array whose outputs lag its input by one register stage is scored correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an evaluation |
| cfg_in_conn | input | 24 | Input-to-first-column connection matrix |
| cfg_mid_conn | input | 128 | Connection matrices between evolvable columns |
| cfg_out_sel | input | 48 | Output selection fields, one per output |
| exp_table | input | 36 | Expected outputs, 6 bits per code |
| arr_out | input | 6 | Outputs returned by the gate array |
| arr_in | output | 3 | Position code driven into the gate array |
| done | output | 1 | Score ready pulse |
| score | output | 6 | Number of matching output bits |

## Verification
The hardest condition to create from the ports is an array that responds late. A block that samples the outputs too early looks correct against any instantaneous array model. The bench therefore models the array as a random lookup table behind one register stage, so a sample taken in the cycle a code is applied reads the previous code's response. A second hard condition is a single rule broken while all the others hold. The bench builds these cases directly. One case covers every input feeding only inputs 0 and 1, which meets the two-connection rule but leaves input 2 unused. Other cases break one cell of a later stage, or one output field. Random valid configurations, some with an injected break, complete the stimulus.

// File: rtl/fte_pkg.sv
package fte_pkg;

    localparam int DEF_IN_W     = 3;
    localparam int DEF_ROWS     = 8;
    localparam int DEF_EVO_COLS = 3;
    localparam int DEF_OUTS     = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SETTLE,
        ST_SAMPLE
    } ev_state_e;

    // Legal codes exclude all-zero and all-one.
    function automatic int vec_count(int in_w);
        return (1 << in_w) - 2;
    endfunction

    function automatic int score_bits(int in_w, int outs);
        return $clog2(vec_count(in_w) * outs + 1);
    endfunction

endpackage

// File: rtl/fte_rules.sv
module fte_rules #(
    parameter int IN_W     = fte_pkg::DEF_IN_W,
    parameter int ROWS     = fte_pkg::DEF_ROWS,
    parameter int EVO_COLS = fte_pkg::DEF_EVO_COLS,
    parameter int OUTS     = fte_pkg::DEF_OUTS
) (
    input  logic [IN_W*ROWS-1:0]                in_conn,
    input  logic [(EVO_COLS-1)*ROWS*ROWS-1:0]   mid_conn,
    input  logic [OUTS*ROWS-1:0]                out_sel,
    output logic                                cfg_ok
);
    localparam int STAGES = EVO_COLS - 1;

    logic [IN_W-1:0]        in_used;
    logic [ROWS-1:0]        first_ok;
    logic [STAGES*ROWS-1:0] stage_ok;
    logic [OUTS-1:0]        sel_ok;

    for (genvar gi = 0; gi < IN_W; gi++) begin : g_in
        logic [ROWS-1:0] fan;
        for (genvar gj = 0; gj < ROWS; gj++) begin : g_fan
            assign fan[gj] = in_conn[gj*IN_W + gi];
        end
        assign in_used[gi] = |fan;
    end

    for (genvar gj = 0; gj < ROWS; gj++) begin : g_first
        assign first_ok[gj] = $countones(in_conn[gj*IN_W +: IN_W]) >= 2;
    end

    for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
        for (genvar gj = 0; gj < ROWS; gj++) begin : g_cell
            assign stage_ok[gs*ROWS + gj] =
                $countones(mid_conn[(gs*ROWS + gj)*ROWS +: ROWS]) >= 2;
        end
    end

    for (genvar go = 0; go < OUTS; go++) begin : g_sel
        assign sel_ok[go] = $countones(out_sel[go*ROWS +: ROWS]) == 1;
    end

    assign cfg_ok = (&in_used) & (&first_ok) & (&stage_ok) & (&sel_ok);

endmodule

// File: rtl/fte_match.sv
module fte_match #(
    parameter int OUTS  = fte_pkg::DEF_OUTS,
    parameter int CNT_W = 6
) (
    input  logic [OUTS-1:0]  got,
    input  logic [OUTS-1:0]  want,
    output logic [CNT_W-1:0] hits
);
    logic [OUTS-1:0] agree;

    assign agree = ~(got ^ want);
    assign hits  = CNT_W'($countones(agree));

endmodule

// File: rtl/fte_eval.sv
module fte_eval #(
    parameter int IN_W     = fte_pkg::DEF_IN_W,
    parameter int ROWS     = fte_pkg::DEF_ROWS,
    parameter int EVO_COLS = fte_pkg::DEF_EVO_COLS,
    parameter int OUTS     = fte_pkg::DEF_OUTS,
    localparam int N_VEC   = fte_pkg::vec_count(IN_W),
    localparam int SCORE_W = fte_pkg::score_bits(IN_W, OUTS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic [IN_W*ROWS-1:0]               cfg_in_conn,
    input  logic [(EVO_COLS-1)*ROWS*ROWS-1:0]  cfg_mid_conn,
    input  logic [OUTS*ROWS-1:0]               cfg_out_sel,
    input  logic [N_VEC*OUTS-1:0]              exp_table,
    input  logic [OUTS-1:0]                    arr_out,
    output logic [IN_W-1:0]                    arr_in,
    output logic                               done,
    output logic [SCORE_W-1:0]                 score
);
    import fte_pkg::*;

    localparam int IDX_W = $clog2(N_VEC);

    ev_state_e          state;
    logic [IDX_W-1:0]   vec_idx;
    logic               cfg_ok;
    logic [SCORE_W-1:0] hits;
    logic [OUTS-1:0]    want_row;

    fte_rules #(
        .IN_W(IN_W), .ROWS(ROWS), .EVO_COLS(EVO_COLS), .OUTS(OUTS)
    ) u_rules (
        .in_conn (cfg_in_conn),
        .mid_conn(cfg_mid_conn),
        .out_sel (cfg_out_sel),
        .cfg_ok  (cfg_ok)
    );

    assign want_row = exp_table[vec_idx*OUTS +: OUTS];

    fte_match #(.OUTS(OUTS), .CNT_W(SCORE_W)) u_match (
        .got (arr_out),
        .want(want_row),
        .hits(hits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            vec_idx <= '0;
            arr_in  <= '0;
            done    <= 1'b0;
            score   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        score   <= '0;
                        vec_idx <= '0;
                        state   <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (cfg_ok) begin
                        arr_in <= IN_W'(1);
                        state  <= ST_SETTLE;
                    end else begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_SETTLE: state <= ST_SAMPLE;
                ST_SAMPLE: begin
                    score <= score + hits;
                    if (vec_idx == IDX_W'(N_VEC - 1)) begin
                        arr_in <= '0;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        vec_idx <= vec_idx + 1'b1;
                        arr_in  <= arr_in + 1'b1;
                        state   <= ST_SETTLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fte_eval_chk.sv
module fte_eval_chk #(
    parameter int IN_W    = 3,
    parameter int SCORE_W = 6,
    parameter int MAX_SC  = 36
) (
    input logic                clk,
    input logic                rst,
    input logic                done,
    input logic [IN_W-1:0]     arr_in,
    input logic [SCORE_W-1:0]  score,
    input fte_pkg::ev_state_e  state,
    input logic                cfg_ok
);
    import fte_pkg::*;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        arr_in != {IN_W{1'b1}});

    // R6
    code_step_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_in != $past(arr_in)) |->
            (arr_in == IN_W'($past(arr_in) + 1'b1) || arr_in == '0));

    // R6
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (arr_in == '0));

    // R7
    score_max_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (score <= SCORE_W'(MAX_SC)));

    // R5
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && !cfg_ok) |=> (done && score == '0 && arr_in == '0));

endmodule

bind fte_eval fte_eval_chk #(
    .IN_W(IN_W), .SCORE_W(SCORE_W), .MAX_SC(N_VEC*OUTS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .done  (done),
    .arr_in(arr_in),
    .score (score),
    .state (state),
    .cfg_ok(cfg_ok)
);

// File: tb/fte_eval_tb.sv
module fte_eval_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [23:0]  cin = '0;
    logic [127:0] cmid = '0;
    logic [47:0]  cout = '0;
    logic [35:0]  etab = '0;
    logic [5:0]   arr_out;
    logic [2:0]   arr_in;
    logic         done;
    logic [5:0]   score;
    logic [5:0]   lut [8];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    fte_eval u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_in_conn(cin), .cfg_mid_conn(cmid), .cfg_out_sel(cout),
        .exp_table(etab), .arr_out(arr_out), .arr_in(arr_in),
        .done(done), .score(score)
    );

    // Array model with one register stage of lag (R10).
    always_ff @(posedge clk) arr_out <= lut[arr_in];

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit cfg_legal();
        bit good = 1;
        for (int i = 0; i < 3; i++) begin
            bit used = 0;
            for (int j = 0; j < 8; j++) if (cin[j*3+i]) used = 1;
            if (!used) good = 0;
        end
        for (int j = 0; j < 8; j++) begin
            int n = 0;
            for (int i = 0; i < 3; i++) n += int'(cin[j*3+i]);
            if (n < 2) good = 0;
        end
        for (int c = 0; c < 16; c++) begin
            int n = 0;
            for (int b = 0; b < 8; b++) n += int'(cmid[c*8+b]);
            if (n < 2) good = 0;
        end
        for (int o = 0; o < 6; o++) begin
            int n = 0;
            for (int b = 0; b < 8; b++) n += int'(cout[o*8+b]);
            if (n != 1) good = 0;
        end
        return good;
    endfunction

    function automatic int model_score();
        int s = 0;
        if (!cfg_legal()) return 0;
        for (int k = 0; k < 6; k++)
            for (int o = 0; o < 6; o++)
                if (lut[k+1][o] == etab[k*6+o]) s++;
        return s;
    endfunction

    task automatic make_valid();
        logic [2:0] masks [4] = '{3'b011, 3'b101, 3'b110, 3'b111};
        for (int j = 0; j < 8; j++) cin[j*3 +: 3] = masks[$urandom % 4];
        for (int i = 0; i < 3; i++) begin
            bit used = 0;
            for (int j = 0; j < 8; j++) if (cin[j*3+i]) used = 1;
            if (!used) cin[i*3+i] = 1'b1;
        end
        for (int c = 0; c < 16; c++) begin
            int a = $urandom % 8;
            int b = (a + 1 + ($urandom % 7)) % 8;
            cmid[c*8 +: 8] = 8'($urandom);
            cmid[c*8+a] = 1'b1;
            cmid[c*8+b] = 1'b1;
        end
        for (int o = 0; o < 6; o++) cout[o*8 +: 8] = 8'b1 << ($urandom % 8);
    endtask

    task automatic random_tables();
        for (int c = 0; c < 8; c++) lut[c] = 6'($urandom);
        for (int k = 0; k < 6; k++) etab[k*6 +: 6] = 6'($urandom);
    endtask

    task automatic run_eval(string tag, int poke_at);
        int want = model_score();
        bit legal = cfg_legal();
        int lat = legal ? 14 : 2;
        int cyc = 0;
        int nseq = 0;
        int seq [8];
        logic [2:0] prev = 3'd0;
        bit seen = 0;
        bit seq_ok;
        @(negedge clk);
        start = 1'b1;
        while (!seen && cyc < 40) begin
            @(negedge clk);
            cyc++;
            start = (cyc == poke_at);
            if (arr_in != prev && arr_in != 3'd0 && nseq < 8) begin
                seq[nseq] = int'(arr_in);
                nseq++;
            end
            prev = arr_in;
            if (done) seen = 1;
        end
        start = 1'b0;
        check(seen && cyc == lat, legal ? "R8" : "R5", {tag, " done latency"}, cyc, lat);
        check(int'(score) == want, legal ? "R7" : "R5", {tag, " score"}, int'(score), want);
        seq_ok = (nseq == (legal ? 6 : 0));
        for (int k = 0; k < nseq && k < 6; k++) if (seq[k] != k + 1) seq_ok = 0;
        check(seq_ok, legal ? "R6" : "R5", {tag, " code sequence"}, nseq, legal ? 6 : 0);
        @(negedge clk);
        check(done == 1'b0, "R8", {tag, " done width"}, int'(done), 0);
        repeat (3) @(negedge clk);
        check(int'(score) == want && arr_in == 3'd0, "R8", {tag, " score held"}, int'(score), want);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 8; c++) lut[c] = 6'd0;
        repeat (3) @(negedge clk);
        // R1
        check(done == 0 && score == 0 && arr_in == 0, "R1", "reset state",
              int'({done, score, arr_in}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R7 R10: perfect match with a lagging array
        random_tables(); make_valid();
        for (int k = 0; k < 6; k++) etab[k*6 +: 6] = lut[k+1];
        run_eval("R10 full match", 0);

        // R7: valid but nothing matches
        for (int k = 0; k < 6; k++) etab[k*6 +: 6] = ~lut[k+1];
        run_eval("R7 zero match", 0);

        // R7: exactly one bit matches
        etab[2*6] = ~etab[2*6];
        run_eval("R7 single bit", 0);

        // R2: every cell uses inputs 0 and 1 only
        make_valid();
        for (int j = 0; j < 8; j++) cin[j*3 +: 3] = 3'b011;
        run_eval("R2 unused input", 0);

        // R3: first-column cell with one connection, inputs still covered
        make_valid();
        for (int j = 0; j < 8; j++) cin[j*3 +: 3] = 3'b111;
        cin[5*3 +: 3] = 3'b100;
        run_eval("R3 first column", 0);

        // R3: later stage cell with one connection
        make_valid();
        cmid[(8+3)*8 +: 8] = 8'b0001_0000;
        run_eval("R3 later stage", 0);

        // R4: output field empty, then with two ones
        make_valid();
        cout[4*8 +: 8] = 8'h00;
        run_eval("R4 no select", 0);
        make_valid();
        cout[1*8 +: 8] = 8'b0100_0010;
        run_eval("R4 two selects", 0);

        // Boundary: exactly two connections everywhere is legal
        for (int j = 0; j < 8; j++) cin[j*3 +: 3] = (j % 2) ? 3'b110 : 3'b011;
        for (int c = 0; c < 16; c++) cmid[c*8 +: 8] = 8'b1000_0001;
        for (int o = 0; o < 6; o++) cout[o*8 +: 8] = 8'h80;
        random_tables();
        run_eval("R3 minimum legal", 0);

        // R9: start raised mid-evaluation is ignored
        make_valid(); random_tables();
        run_eval("R9 restart ignored", 5);
        begin
            bit extra = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (done) extra = 1;
            end
            check(!extra, "R9", "no second done", int'(extra), 0);
        end

        // Random mix with occasional injected breaks
        for (int t = 0; t < 40; t++) begin
            make_valid(); random_tables();
            case ($urandom % 6)
                0: begin
                    int i = $urandom % 3;
                    for (int j = 0; j < 8; j++) cin[j*3+i] = 1'b0;
                end
                1: cmid[($urandom % 16)*8 +: 8] = 8'b1 << ($urandom % 8);
                2: cout[($urandom % 6)*8 +: 8] = 8'h00;
                default: ;
            endcase
            run_eval("random", 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule